// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the address and acknowledge stage of an I2C slave. A bus front end, which is not part of this block, filters the pins and delivers single-cycle events in the system clock domain:
- a START event, also raised for a repeated START;
- a STOP event;
- a bit event carrying the SDA value sampled on each rising SCL edge;
- an event for each falling SCL edge.

The recognizer shifts in the address byte, or two bytes in 10-bit mode, and compares them with a programmable own address. It also recognises the General Call address and the START byte. On a match it pulses a match interrupt. It pulls SDA low during the acknowledge slot when the host's NAK control bit is clear.

In software-recognition mode the hardware comparison is bypassed. Every received byte is handed to the host with a receive pulse. The block holds SCL low from the falling edge that opens the acknowledge slot until the host writes its control strobe. The NAK value written with that strobe then sets the acknowledge.

The control is one state machine with these states:
- ST_IDLE: the bus is free or the block has stopped.
- ST_FIRST: the first address byte is being received.
- ST_SECOND: the second byte of a 10-bit address is being received.
- ST_DATA: bytes after a successful address phase are being received.
- ST_SKIP: the transfer is not for this slave.
- ST_ACKWAIT: the eight bits are in, waiting for SCL to fall.
- ST_HOLD: SCL is being stretched for the host.
- ST_DRIVE: the acknowledge value is on SDA before the ninth rising edge.
- ST_TAIL: the acknowledge value is held until the ninth falling edge.

The transitions are:
- byte_done: ST_FIRST, ST_SECOND or ST_DATA go to ST_ACKWAIT or ST_SKIP.
- open_ack: ST_ACKWAIT goes to ST_HOLD or ST_DRIVE on the SCL fall.
- host_go: ST_HOLD goes to ST_DRIVE on the host strobe.
- ninth_rise: ST_DRIVE goes to ST_TAIL.
- close_ack: ST_TAIL goes to the stored resume state on the SCL fall.
- restart: any state goes to ST_FIRST on START.
- halt: any state goes to ST_IDLE on STOP.

Top module: `i2c_addr_recog`

## Requirements
- R1: With ten_bit=0 and sw_mode=0, a first byte whose bits 7:1 equal own_addr[6:0] pulses match_irq for exactly one cycle, starting the cycle after the eighth bit event. It leaves gc_hit=0.
- R2: When the first byte matches neither the own address, the General Call nor the START byte, there is no match_irq and no rx_irq for the rest of the transfer. SDA and SCL stay released, and later bytes are ignored.
- R3: With ten_bit=1, a first byte equal to {11110, own_addr[9:8], 0} is acknowledged without match_irq. A second byte equal to own_addr[7:0] then pulses match_irq and is acknowledged. A mismatch in either byte releases the bus. A 7-bit style match is not recognised in this mode.
- R4: With gc_en=1, a first byte of 0x00 pulses match_irq and sets gc_hit=1 and gc_rw=0. It is acknowledged when host_nak=0 and not acknowledged when host_nak=1. With gc_en=0 the byte is ignored.
- R5: With gc_en=1, a first byte of 0x01 pulses match_irq and sets gc_hit=1 and gc_rw=1. sda_low is never asserted for the rest of that transfer.
- R6: When a byte is acknowledged, sda_low is high from the SCL fall after the eighth bit up to the SCL fall after the ninth bit. For a not-acknowledged byte, sda_low stays low.
- R7: With sw_mode=1, no hardware match is made and match_irq stays low. Every received byte pulses rx_irq one cycle after its eighth bit, with the byte on rx_data.
- R8: With sw_mode=1, scl_low rises on the SCL fall that opens the acknowledge slot and stays high until host_wr. One cycle after host_wr, scl_low is low and sda_low equals the inverse of host_nak.
- R9: After a write-direction address match, each data byte pulses rx_irq. With sw_mode=0 it is acknowledged from host_nak. Setting sw_mode after the match makes the following data bytes stretch SCL as in R8.
- R10: A STOP or repeated START releases sda_low and scl_low on the next cycle, including during a hold. A START begins a new address phase.
- R11: A 7-bit match with R/W=1 is acknowledged. After that the block releases the bus and ignores the rest of the transfer.
- R12: After reset, sda_low, scl_low, match_irq, rx_irq, gc_hit and gc_rw are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | START or repeated START seen (one cycle) |
| stop_evt | input | 1 | STOP seen (one cycle) |
| bit_vld | input | 1 | SDA sampled on a rising SCL edge (one cycle) |
| bit_dat | input | 1 | Value sampled with bit_vld |
| scl_fall | input | 1 | Falling SCL edge seen (one cycle) |
| own_addr | input | 10 | Own slave address; bits 6:0 are used in 7-bit mode |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| gc_en | input | 1 | Enables General Call and START byte recognition |
| sw_mode | input | 1 | Software-recognition mode |
| host_nak | input | 1 | Host NAK control: 0 acknowledges, 1 does not |
| host_wr | input | 1 | Host control write strobe that ends an SCL hold |
| sda_low | output | 1 | Pull SDA low |
| scl_low | output | 1 | Hold SCL low |
| match_irq | output | 1 | One-cycle address match interrupt |
| gc_hit | output | 1 | Last match was General Call or START byte |
| gc_rw | output | 1 | 0 for General Call, 1 for START byte |
| rx_irq | output | 1 | One-cycle byte received interrupt |
| rx_data | output | 8 | Last byte handed to the host |

## Verification
The checks assume the front end delivers events in legal bus order, so a START or STOP never coincides with another event. Each bit event is followed by an SCL fall before the next bit event. The checks also assume the host strobes host_wr only while it is answering a hold. The bench keeps within this by issuing every event as a separate one-cycle pulse through tasks that reproduce that order. During a hold it issues no ninth bit until after host_wr. It sweeps all 128 seven-bit addresses and all four 10-bit header values, and computes the expected match and acknowledge from the programmed address.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int SHORT_W = 7;
    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_DATA,
        ST_SKIP,
        ST_ACKWAIT,
        ST_HOLD,
        ST_DRIVE,
        ST_TAIL
    } ar_state_t;

endpackage

// File: rtl/i2c_ar_shift.sv
module i2c_ar_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_vld,
    input  logic         bit_dat,
    output logic         byte_done,
    output logic [W-1:0] byte_q
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && bit_vld) begin
            sh <= {sh[W-2:0], bit_dat};
            if (cnt == CW'(W-1)) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
        end
    end

    assign byte_done = en && bit_vld && (cnt == CW'(W-1));
    assign byte_q    = {sh[W-2:0], bit_dat};

endmodule

// File: rtl/i2c_ar_match.sv
module i2c_ar_match
    import i2c_ar_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              gc_en,
    output logic              hit_gc,
    output logic              hit_sb,
    output logic              hit_short,
    output logic              hit_hdr,
    output logic              hit_low
);
    logic zero_addr;

    always_comb begin
        zero_addr = (rx_byte[BYTE_W-1:1] == '0);
        hit_gc    = gc_en && zero_addr && !rx_byte[0];
        hit_sb    = gc_en && zero_addr &&  rx_byte[0];
        hit_short = !ten_bit && (rx_byte[BYTE_W-1:1] == own_addr[SHORT_W-1:0]);
        hit_hdr   = ten_bit && (rx_byte == {TEN_HDR, own_addr[ADDR_W-1:BYTE_W], 1'b0});
        hit_low   = ten_bit && (rx_byte == own_addr[BYTE_W-1:0]);
    end

endmodule

// File: rtl/i2c_ar_fsm.sv
module i2c_ar_fsm
    import i2c_ar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_vld,
    input  logic              scl_fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              hit_gc,
    input  logic              hit_sb,
    input  logic              hit_short,
    input  logic              hit_hdr,
    input  logic              hit_low,
    input  logic              sw_mode,
    input  logic              host_nak,
    input  logic              host_wr,
    output logic              rx_en,
    output logic              sda_low,
    output logic              scl_low,
    output logic              match_irq,
    output logic              gc_hit,
    output logic              gc_rw,
    output logic              rx_irq,
    output logic [BYTE_W-1:0] rx_data
);
    ar_state_t         state_q, state_n;
    ar_state_t         resume_q, resume_n;
    logic              ack_q, ack_n;
    logic              host_q, host_n;
    logic              mirq_q, mirq_n;
    logic              rirq_q, rirq_n;
    logic              gch_q, gch_n;
    logic              gcr_q, gcr_n;
    logic [BYTE_W-1:0] rxd_q, rxd_n;

    // next-state and next-register logic
    always_comb begin
        state_n  = state_q;
        resume_n = resume_q;
        ack_n    = ack_q;
        host_n   = host_q;
        mirq_n   = 1'b0;
        rirq_n   = 1'b0;
        gch_n    = gch_q;
        gcr_n    = gcr_q;
        rxd_n    = rxd_q;
        if (stop_evt) begin
            state_n = ST_IDLE;
            ack_n   = 1'b0;
            host_n  = 1'b0;
        end else if (start_evt) begin
            state_n = ST_FIRST;
            ack_n   = 1'b0;
            host_n  = 1'b0;
            gch_n   = 1'b0;
            gcr_n   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_FIRST: begin
                    if (byte_done) begin
                        if (sw_mode) begin
                            rirq_n   = 1'b1;
                            rxd_n    = rx_byte;
                            host_n   = 1'b1;
                            ack_n    = 1'b0;
                            resume_n = ST_DATA;
                            state_n  = ST_ACKWAIT;
                        end else if (hit_gc) begin
                            mirq_n   = 1'b1;
                            gch_n    = 1'b1;
                            gcr_n    = 1'b0;
                            host_n   = 1'b0;
                            ack_n    = !host_nak;
                            resume_n = ST_DATA;
                            state_n  = ST_ACKWAIT;
                        end else if (hit_sb) begin
                            mirq_n   = 1'b1;
                            gch_n    = 1'b1;
                            gcr_n    = 1'b1;
                            state_n  = ST_SKIP;
                        end else if (hit_short) begin
                            mirq_n   = 1'b1;
                            host_n   = 1'b0;
                            ack_n    = !host_nak;
                            resume_n = rx_byte[0] ? ST_SKIP : ST_DATA;
                            state_n  = ST_ACKWAIT;
                        end else if (hit_hdr) begin
                            host_n   = 1'b0;
                            ack_n    = !host_nak;
                            resume_n = ST_SECOND;
                            state_n  = ST_ACKWAIT;
                        end else begin
                            state_n  = ST_SKIP;
                        end
                    end
                end
                ST_SECOND: begin
                    if (byte_done) begin
                        if (sw_mode) begin
                            rirq_n   = 1'b1;
                            rxd_n    = rx_byte;
                            host_n   = 1'b1;
                            ack_n    = 1'b0;
                            resume_n = ST_DATA;
                            state_n  = ST_ACKWAIT;
                        end else if (hit_low) begin
                            mirq_n   = 1'b1;
                            host_n   = 1'b0;
                            ack_n    = !host_nak;
                            resume_n = ST_DATA;
                            state_n  = ST_ACKWAIT;
                        end else begin
                            state_n  = ST_SKIP;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        rirq_n   = 1'b1;
                        rxd_n    = rx_byte;
                        host_n   = sw_mode;
                        ack_n    = sw_mode ? 1'b0 : !host_nak;
                        resume_n = ST_DATA;
                        state_n  = ST_ACKWAIT;
                    end
                end
                ST_SKIP: begin
                end
                ST_ACKWAIT: begin
                    if (scl_fall) state_n = host_q ? ST_HOLD : ST_DRIVE;
                end
                ST_HOLD: begin
                    if (host_wr) begin
                        ack_n   = !host_nak;
                        host_n  = 1'b0;
                        state_n = ST_DRIVE;
                    end
                end
                ST_DRIVE: begin
                    if (bit_vld) state_n = ST_TAIL;
                end
                ST_TAIL: begin
                    if (scl_fall) begin
                        ack_n   = 1'b0;
                        state_n = resume_q;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            resume_q <= ST_IDLE;
            ack_q    <= 1'b0;
            host_q   <= 1'b0;
            mirq_q   <= 1'b0;
            rirq_q   <= 1'b0;
            gch_q    <= 1'b0;
            gcr_q    <= 1'b0;
            rxd_q    <= '0;
        end else begin
            state_q  <= state_n;
            resume_q <= resume_n;
            ack_q    <= ack_n;
            host_q   <= host_n;
            mirq_q   <= mirq_n;
            rirq_q   <= rirq_n;
            gch_q    <= gch_n;
            gcr_q    <= gcr_n;
            rxd_q    <= rxd_n;
        end
    end

    // outputs
    always_comb begin
        rx_en     = (state_q == ST_FIRST) || (state_q == ST_SECOND) || (state_q == ST_DATA);
        sda_low   = ack_q && ((state_q == ST_DRIVE) || (state_q == ST_TAIL));
        scl_low   = (state_q == ST_HOLD);
        match_irq = mirq_q;
        rx_irq    = rirq_q;
        gc_hit    = gch_q;
        gc_rw     = gcr_q;
        rx_data   = rxd_q;
    end

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_low && !scl_low));

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low && !host_wr && !start_evt && !stop_evt) |=> scl_low);

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low && host_wr && !start_evt && !stop_evt) |=> !scl_low);

    // R5
    sbyte_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gc_hit && gc_rw) |-> !sda_low);

    // R1
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq);

    // R6
    sda_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> !rx_en);

endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
    import i2c_ar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_vld,
    input  logic              bit_dat,
    input  logic              scl_fall,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              gc_en,
    input  logic              sw_mode,
    input  logic              host_nak,
    input  logic              host_wr,
    output logic              sda_low,
    output logic              scl_low,
    output logic              match_irq,
    output logic              gc_hit,
    output logic              gc_rw,
    output logic              rx_irq,
    output logic [BYTE_W-1:0] rx_data
);
    logic              rx_en;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              hit_gc, hit_sb, hit_short, hit_hdr, hit_low;

    i2c_ar_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_evt || stop_evt),
        .en        (rx_en),
        .bit_vld   (bit_vld),
        .bit_dat   (bit_dat),
        .byte_done (byte_done),
        .byte_q    (rx_byte)
    );

    i2c_ar_match u_match (
        .rx_byte   (rx_byte),
        .own_addr  (own_addr),
        .ten_bit   (ten_bit),
        .gc_en     (gc_en),
        .hit_gc    (hit_gc),
        .hit_sb    (hit_sb),
        .hit_short (hit_short),
        .hit_hdr   (hit_hdr),
        .hit_low   (hit_low)
    );

    i2c_ar_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .bit_vld   (bit_vld),
        .scl_fall  (scl_fall),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .hit_gc    (hit_gc),
        .hit_sb    (hit_sb),
        .hit_short (hit_short),
        .hit_hdr   (hit_hdr),
        .hit_low   (hit_low),
        .sw_mode   (sw_mode),
        .host_nak  (host_nak),
        .host_wr   (host_wr),
        .rx_en     (rx_en),
        .sda_low   (sda_low),
        .scl_low   (scl_low),
        .match_irq (match_irq),
        .gc_hit    (gc_hit),
        .gc_rw     (gc_rw),
        .rx_irq    (rx_irq),
        .rx_data   (rx_data)
    );

endmodule

// File: tb/sim_i2c_addr_recog.sv
`timescale 1ns/1ps
module sim_i2c_addr_recog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0, stop_evt = 1'b0, bit_vld = 1'b0, bit_dat = 1'b0, scl_fall = 1'b0;
    logic [9:0] own_addr = 10'h2D5;
    logic       ten_bit = 1'b0, gc_en = 1'b1, sw_mode = 1'b0, host_nak = 1'b0, host_wr = 1'b0;
    logic       sda_low, scl_low, match_irq, gc_hit, gc_rw, rx_irq;
    logic [7:0] rx_data;

    int n_run = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_recog u0 (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .bit_vld(bit_vld), .bit_dat(bit_dat), .scl_fall(scl_fall),
        .own_addr(own_addr), .ten_bit(ten_bit), .gc_en(gc_en), .sw_mode(sw_mode),
        .host_nak(host_nak), .host_wr(host_wr), .sda_low(sda_low), .scl_low(scl_low),
        .match_irq(match_irq), .gc_hit(gc_hit), .gc_rw(gc_rw), .rx_irq(rx_irq),
        .rx_data(rx_data)
    );

    always @(posedge clk) begin
        if (match_irq) irq_cnt++;
        if (rx_irq) begin
            rx_cnt++;
            rx_last = rx_data;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic p_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask

    task automatic p_stop();
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
    endtask

    task automatic p_bit(input logic b);
        @(negedge clk) begin bit_vld = 1'b1; bit_dat = b; end
        @(negedge clk) bit_vld = 1'b0;
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask

    task automatic p_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) p_bit(b[i]);
    endtask

    task automatic p_host(input logic nak);
        @(negedge clk) begin host_nak = nak; host_wr = 1'b1; end
        @(negedge clk) host_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int i0, r0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 sda", sda_low, 0);
        chk("R12 scl", scl_low, 0);
        chk("R12 irq", match_irq, 0);
        chk("R12 rx", rx_irq, 0);
        chk("R12 gc", {gc_hit, gc_rw}, 0);
        rst_n = 1'b1;

        // R1 R2 R4 R6 R9: sweep every 7-bit address, write direction
        for (int a = 0; a < 128; a++) begin
            int exp_m;
            exp_m = (a == 7'h55 || a == 0) ? 1 : 0;
            i0 = irq_cnt; r0 = rx_cnt;
            p_start();
            p_byte({a[6:0], 1'b0});
            chk("R1 R2 R4 irq", irq_cnt - i0, exp_m);
            chk("R6 ack", sda_low, exp_m);
            if (a == 0) chk("R4 gc flags", {gc_hit, gc_rw}, 2);
            if (a == 7'h55) chk("R1 gc_hit", gc_hit, 0);
            p_bit(1'b1);
            chk("R6 ack end", sda_low, 0);
            p_byte(8'h5A);
            chk("R9 R2 data ack", sda_low, exp_m);
            chk("R9 R2 rx", rx_cnt - r0, exp_m);
            p_bit(1'b1);
            p_stop();
            @(negedge clk);
            chk("R10 released", {sda_low, scl_low}, 0);
        end

        // R4 General Call with NAK
        host_nak = 1'b1; i0 = irq_cnt;
        p_start(); p_byte(8'h00);
        chk("R4 gc nak irq", irq_cnt - i0, 1);
        chk("R4 gc nak sda", sda_low, 0);
        p_bit(1'b1); p_stop(); host_nak = 1'b0;

        // R4 General Call disabled
        gc_en = 1'b0; i0 = irq_cnt;
        p_start(); p_byte(8'h00);
        chk("R4 gc off irq", irq_cnt - i0, 0);
        chk("R4 gc off sda", sda_low, 0);
        p_stop(); gc_en = 1'b1;

        // R5 START byte
        i0 = irq_cnt;
        p_start(); p_byte(8'h01);
        chk("R5 sb irq", irq_cnt - i0, 1);
        chk("R5 sb flags", {gc_hit, gc_rw}, 3);
        chk("R5 sb sda", sda_low, 0);
        p_bit(1'b1); p_byte(8'h00);
        chk("R5 sb later sda", sda_low, 0);
        p_stop();

        // R11 read direction match
        i0 = irq_cnt; r0 = rx_cnt;
        p_start(); p_byte(8'hAB);
        chk("R11 irq", irq_cnt - i0, 1);
        chk("R11 ack", sda_low, 1);
        p_bit(1'b1); p_byte(8'h00);
        chk("R11 released", sda_low, 0);
        chk("R11 no rx", rx_cnt - r0, 0);
        p_stop();

        // R3 10-bit: sweep header high bits
        ten_bit = 1'b1;
        for (int hb = 0; hb < 4; hb++) begin
            int eh;
            eh = (hb == 2) ? 1 : 0;
            i0 = irq_cnt;
            p_start(); p_byte({5'b11110, hb[1:0], 1'b0});
            chk("R3 hdr no irq", irq_cnt - i0, 0);
            chk("R3 hdr ack", sda_low, eh);
            p_bit(1'b1);
            p_byte(8'hD5);
            chk("R3 low irq", irq_cnt - i0, eh);
            chk("R3 low ack", sda_low, eh);
            p_bit(1'b1); p_stop();
        end
        i0 = irq_cnt;
        p_start(); p_byte(8'hF4); p_bit(1'b1); p_byte(8'hD4);
        chk("R3 low miss irq", irq_cnt - i0, 0);
        chk("R3 low miss sda", sda_low, 0);
        p_stop();
        p_start(); p_byte(8'hAA);
        chk("R3 no short match", irq_cnt - i0, 0);
        p_stop();
        ten_bit = 1'b0;

        // R7 R8 software recognition
        sw_mode = 1'b1; i0 = irq_cnt; r0 = rx_cnt;
        p_start(); p_byte(8'h33);
        chk("R7 rx", rx_cnt - r0, 1);
        chk("R7 data", rx_last, 8'h33);
        chk("R7 no irq", irq_cnt - i0, 0);
        chk("R8 hold", scl_low, 1);
        repeat (20) @(negedge clk);
        chk("R8 hold kept", scl_low, 1);
        p_host(1'b0);
        chk("R8 release", scl_low, 0);
        chk("R8 ack", sda_low, 1);
        p_bit(1'b1);
        p_byte(8'hC4);
        chk("R7 rx2", rx_last, 8'hC4);
        chk("R8 hold2", scl_low, 1);
        p_host(1'b1);
        chk("R8 nak", {sda_low, scl_low}, 0);
        p_bit(1'b1);
        p_byte(8'h77);
        p_stop();
        @(negedge clk);
        chk("R10 stop in hold", scl_low, 0);
        p_start(); p_byte(8'h12);
        chk("R8 hold3", scl_low, 1);
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
        chk("R10 restart in hold", scl_low, 0);
        sw_mode = 1'b0; host_nak = 1'b0; i0 = irq_cnt;
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
        p_byte(8'hAA);
        chk("R10 new phase irq", irq_cnt - i0, 1);
        p_bit(1'b1);

        // R9 software mode entered after match
        sw_mode = 1'b1; r0 = rx_cnt;
        p_byte(8'h9E);
        chk("R9 sw after match rx", rx_cnt - r0, 1);
        chk("R9 sw after match hold", scl_low, 1);
        p_host(1'b0);
        chk("R9 sw after match ack", {sda_low, scl_low}, 2);
        p_bit(1'b1); p_stop(); sw_mode = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule